// File: doc/BRIEF.md
# Dual-Timing-Mode Synchronous FIFO

This block is a single-clock first-in first-out buffer of 256 words by 36 bits. Its read side follows one of two timing behaviours. The behaviour is chosen once, at the first clock edge that the core sees after a master reset.

In **standard** mode, a word reaches the output only when the consumer explicitly asks for it, and that includes the first word. The two status outputs mean "not empty" and "not full". In **fall-through** mode, the oldest word is moved into the output register without any request. The same two outputs then mean "output holds a valid word" and "input can accept a word". Because the output register holds one extra word, the capacity in this mode is one word larger.

Two further flags give early warning: an active-low almost-empty flag and an active-low almost-full flag. A partial reset empties the buffer and clears every flag but keeps the selected mode. Both resets assert asynchronously and are released through two-stage synchronisers.

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_sel` is captured at the third rising edge after `rst_n` goes high. A value of 1 selects standard mode and 0 selects fall-through mode. Later changes of `mode_sel` have no effect until the next master reset.
- R2: `space_ok` stays low while either reset is low. After `rst_n` or `prst_n` goes high, it is still low after the third rising edge and goes high at the fourth rising edge.
- R3: While `rst_n` is low, the outputs hold these values: `data_ok`=0, `space_ok`=0, `ae_n`=0, `af_n`=1 and `rd_data`=0.
- R4: In standard mode, `rd_data` changes only at an edge where `rd_en` and `data_ok` are both high, and it then shows the oldest stored word. `data_ok` is high exactly while at least one word is stored.
- R5: In fall-through mode, a word written into an empty FIFO at edge N appears on `rd_data`, with `data_ok` high, after edge N+1 and without any read. It stays there until an edge with `rd_en` high. At that edge the next word replaces it, or `data_ok` falls if no word remains.
- R6: The capacity is 256 words in standard mode and 257 in fall-through mode. `space_ok` is high exactly while fewer words than the capacity are held. A write made while `space_ok` is low stores nothing.
- R7: A read made while `data_ok` is low leaves `rd_data` unchanged.
- R8: Let the fill count include the word on the output in fall-through mode. `ae_n` is low when the fill count is 8 or less. `af_n` is low when the free space is 8 or less. Both flags update at the same edge as the write or read that changes the count.
- R9: A partial reset (`prst_n` low) discards all stored words and sets the flags to their reset values. After it ends, the mode chosen at the last master reset is still in force, whatever level `mode_sel` has.
- R10: Words leave the FIFO in the order they were written, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, active low; asserts asynchronously |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| mode_sel | input | 1 | Timing mode: 1 = standard, 0 = fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read word (registered) |
| space_ok | output | 1 | Standard: not full. Fall-through: input ready |
| data_ok | output | 1 | Standard: not empty. Fall-through: output valid |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
The following outputs are due one edge after their cause:
- a standard-mode read on `rd_data`;
- the effect of a write or read on `space_ok`, `data_ok`, `ae_n` and `af_n`.

The following outputs need more edges:
- a first word in fall-through mode needs two edges before it is shown;
- the mode is captured three edges after a reset is released;
- `space_ok` rises four edges after a reset is released.

The bench drives its inputs just after a rising edge and samples 1 ns after the edge that the count names. Each check therefore observes the value due in that cycle, and never one a cycle early or late. The fill tests rebuild the expected flag levels from the number of writes accepted so far, using the capacity of the mode under test.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_STD  = 1'b1
  } rd_mode_e;

  localparam int WARM_CYCLES = 2;
endpackage

// File: rtl/dtf_rst_sync.sv
module dtf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dtf_mem.sv
module dtf_mem #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dtf_outreg.sv
module dtf_outreg #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] dout_d;

  always_comb begin
    dout_d = dout;
    if (load) dout_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= dout_d;
  end
endmodule

// File: rtl/dtf_ctrl.sv
module dtf_ctrl
  import dtf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_OFF = 8,
  parameter int AF_OFF = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          core_rst_n,
  input  logic          mst_rst_n,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          load_out,
  output logic          space_ok,
  output logic          data_ok,
  output logic          ae_n,
  output logic          af_n,
  output logic          mode_std,
  output logic [CW-1:0] fill
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] AE_C    = CW'(AE_OFF);
  localparam logic [CW-1:0] AF_C    = CW'(AF_OFF);
  localparam logic [1:0]    WARM_C  = 2'(WARM_CYCLES);

  // mode latch: master reset only
  rd_mode_e mode_q;
  logic     locked_q;

  always_ff @(posedge clk or negedge mst_rst_n) begin
    if (!mst_rst_n) begin
      mode_q   <= MODE_STD;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= rd_mode_e'(mode_sel);
      locked_q <= 1'b1;
    end
  end

  // pointer / count / flag state
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;
  logic [1:0]    warm_q, warm_d;
  logic          space_q, space_d, data_q, data_d, ae_q, ae_d, af_q, af_d;

  logic          is_std, wr_ok, pop;
  logic [CW-1:0] tot_d, cap_c;

  always_comb begin
    is_std = (mode_q == MODE_STD);
    wr_ok  = wr_en & space_q;
    if (is_std) begin
      pop   = rd_en & (cnt_q != '0);
      vld_d = 1'b0;
    end else begin
      pop   = (cnt_q != '0) & (~vld_q | rd_en);
      vld_d = pop | (vld_q & ~rd_en);
    end
    cnt_d  = cnt_q + CW'(wr_ok) - CW'(pop);
    wp_d   = wr_ok ? wp_q + AW'(1) : wp_q;
    rp_d   = pop ? rp_q + AW'(1) : rp_q;
    warm_d = (warm_q == WARM_C) ? warm_q : warm_q + 2'd1;

    tot_d   = cnt_d + CW'(vld_d);
    cap_c   = is_std ? DEPTH_C : DEPTH_C + CW'(1);
    space_d = (warm_d == WARM_C) && (cnt_d < DEPTH_C);
    data_d  = is_std ? (cnt_d != '0) : vld_d;
    ae_d    = tot_d > AE_C;
    af_d    = tot_d < (cap_c - AF_C);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      warm_q  <= '0;
      space_q <= 1'b0;
      data_q  <= 1'b0;
      ae_q    <= 1'b0;
      af_q    <= 1'b1;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      warm_q  <= warm_d;
      space_q <= space_d;
      data_q  <= data_d;
      ae_q    <= ae_d;
      af_q    <= af_d;
    end
  end

  assign mem_we   = wr_ok;
  assign waddr    = wp_q;
  assign raddr    = rp_q;
  assign load_out = pop;
  assign space_ok = space_q;
  assign data_ok  = data_q;
  assign ae_n     = ae_q;
  assign af_n     = af_q;
  assign mode_std = is_std;
  assign fill     = cnt_q + CW'(vld_q);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int WIDTH       = 36,
  parameter int DEPTH       = 256,
  parameter int AE_OFF      = 8,
  parameter int AF_OFF      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prst_n,
  input  logic             mode_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             space_ok,
  output logic             data_ok,
  output logic             ae_n,
  output logic             af_n
);
  logic             mst_sync_n, prt_sync_n, core_rst_n;
  logic             mem_we, load_out, mode_std;
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] mem_rdata;
  logic [CW-1:0]    fill;

  dtf_rst_sync #(.STAGES(SYNC_STAGES)) u_mst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(mst_sync_n)
  );

  dtf_rst_sync #(.STAGES(SYNC_STAGES)) u_prt_sync (
    .clk(clk), .arst_n(prst_n), .srst_n(prt_sync_n)
  );

  assign core_rst_n = mst_sync_n & prt_sync_n;

  dtf_ctrl #(.DEPTH(DEPTH), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) u_ctrl (
    .clk(clk), .core_rst_n(core_rst_n), .mst_rst_n(mst_sync_n),
    .mode_sel(mode_sel), .wr_en(wr_en), .rd_en(rd_en),
    .mem_we(mem_we), .waddr(waddr), .raddr(raddr), .load_out(load_out),
    .space_ok(space_ok), .data_ok(data_ok), .ae_n(ae_n), .af_n(af_n),
    .mode_std(mode_std), .fill(fill)
  );

  dtf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dtf_outreg #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(core_rst_n), .load(load_out),
    .din(mem_rdata), .dout(rd_data)
  );
endmodule

// File: rtl/dtf_checker.sv
module dtf_checker #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prst_n,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             space_ok,
  input logic             data_ok,
  input logic             ae_n,
  input logic             mode_std,
  input logic [CW-1:0]    fill
);
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    fill <= CW'(DEPTH + 1));

  a_r7_std_hold: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (mode_std && !(rd_en && data_ok)) |=> $stable(rd_data));

  a_r5_fall_hold: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (!mode_std && data_ok && !rd_en) |=> (data_ok && $stable(rd_data)));

  // R8: an empty FIFO is always almost empty (offset of at least one)
  a_r8_empty_is_ae: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    !data_ok |-> !ae_n);

  a_r2_ready_late: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    $rose(space_ok) |-> ($past(rst_n, 2) && $past(prst_n, 2)));
endmodule

bind dual_mode_fifo dtf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .rd_en(rd_en), .rd_data(rd_data),
  .space_ok(space_ok), .data_ok(data_ok), .ae_n(ae_n),
  .mode_std(mode_std), .fill(fill)
);

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
  localparam int W = 36;

  logic         clk, rst_n, prst_n, mode_sel, wr_en, rd_en;
  logic [W-1:0] wr_data, rd_data;
  logic         space_ok, data_ok, ae_n, af_n;

  int n_cmp = 0;
  int n_bad = 0;

  dual_mode_fifo u0 (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .space_ok(space_ok), .data_ok(data_ok), .ae_n(ae_n), .af_n(af_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic         wr;
    logic [W-1:0] wd;
    logic         rd;
    logic         dok;
    logic [W-1:0] rdx;
  } vec_t;

  // standard-mode walk (R1, R4, R7, R10); expectations hold after the edge
  localparam vec_t VEC [8] = '{
    '{1'b1, 36'h1_0000_00A1, 1'b0, 1'b1, 36'h0},
    '{1'b0, 36'h0,           1'b0, 1'b1, 36'h0},
    '{1'b1, 36'h2_0000_00A2, 1'b1, 1'b1, 36'h1_0000_00A1},
    '{1'b0, 36'h0,           1'b1, 1'b0, 36'h2_0000_00A2},
    '{1'b0, 36'h0,           1'b1, 1'b0, 36'h2_0000_00A2},
    '{1'b1, 36'h3_0000_00A3, 1'b0, 1'b1, 36'h2_0000_00A2},
    '{1'b1, 36'h4_0000_00A4, 1'b1, 1'b1, 36'h3_0000_00A3},
    '{1'b0, 36'h0,           1'b1, 1'b0, 36'h4_0000_00A4}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fval(input int k);
    return {4'hA, 32'(k)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_sel = m; wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R3 space_ok in reset", space_ok, 0);
    chk("R3 data_ok in reset", data_ok, 0);
    chk("R3 ae_n in reset", ae_n, 0);
    chk("R3 af_n in reset", af_n, 1);
    chk("R3 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R2 space_ok after 3rd edge", space_ok, 0);
    tick();
    chk("R2 space_ok after 4th edge", space_ok, 1);
  endtask

  task automatic fill_drain(input int cap, input logic fall);
    int k = 0;
    for (int it = 0; it < cap + 2; it++) begin
      logic acc;
      acc = space_ok;
      wr_en = 1'b1; wr_data = fval(k);
      tick();
      if (acc) k++;
      chk("R6 space_ok during fill", space_ok, (k < cap));
      chk("R8 ae_n during fill", ae_n, (k > 8));
      chk("R8 af_n during fill", af_n, (k < cap - 8));
    end
    wr_en = 1'b0;
    chk("R6 accepted word count", k, cap);
    for (int j = 0; j < cap; j++) begin
      if (fall) begin
        chk("R5 data_ok before read", data_ok, 1);
        chk("R10 fall-through order", rd_data, fval(j));
        rd_en = 1'b1; tick();
      end else begin
        rd_en = 1'b1; tick();
        chk("R10 standard order", rd_data, fval(j));
      end
    end
    chk("R6 empty after drain", data_ok, 0);
    tick();
    chk("R7 read on empty keeps rd_data", rd_data, fval(cap - 1));
    rd_en = 1'b0;
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prst_n = 1'b1; mode_sel = 1'b1;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;

    // standard mode; mode_sel flipped afterwards must be ignored (R1)
    do_reset(1'b1);
    mode_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i].wr; wr_data = VEC[i].wd; rd_en = VEC[i].rd;
      tick();
      chk("R4 data_ok vector", data_ok, VEC[i].dok);
      chk("R1 R4 rd_data vector", rd_data, VEC[i].rdx);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    fill_drain(256, 1'b0);

    // fall-through mode
    do_reset(1'b0);
    wr_en = 1'b1; wr_data = 36'hB_0000_0001; tick();
    wr_en = 1'b0;
    chk("R5 not shown after write edge", data_ok, 0);
    tick();
    chk("R5 shown after second edge", data_ok, 1);
    chk("R1 R5 first word falls through", rd_data, 36'hB_0000_0001);
    wr_en = 1'b1; wr_data = 36'hB_0000_0002; tick();
    wr_data = 36'hB_0000_0003; tick();
    wr_en = 1'b0;
    chk("R5 held without read", rd_data, 36'hB_0000_0001);
    rd_en = 1'b1; tick();
    chk("R5 R10 next word after read", rd_data, 36'hB_0000_0002);
    tick();
    chk("R5 R10 third word", rd_data, 36'hB_0000_0003);
    chk("R5 still valid", data_ok, 1);
    tick();
    rd_en = 1'b0;
    chk("R5 data_ok falls when drained", data_ok, 0);
    chk("R7 stale word kept", rd_data, 36'hB_0000_0003);
    fill_drain(257, 1'b1);

    // partial reset keeps fall-through mode (R9)
    wr_en = 1'b1; wr_data = 36'hC_0000_0001; tick();
    wr_data = 36'hC_0000_0002; tick();
    wr_en = 1'b0; tick();
    prst_n = 1'b0; mode_sel = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 data_ok in partial reset", data_ok, 0);
    chk("R9 space_ok in partial reset", space_ok, 0);
    chk("R9 ae_n in partial reset", ae_n, 0);
    chk("R9 af_n in partial reset", af_n, 1);
    prst_n = 1'b1;
    tick(); tick(); tick();
    chk("R2 space_ok 3rd edge after partial", space_ok, 0);
    tick();
    chk("R2 space_ok 4th edge after partial", space_ok, 1);
    chk("R9 contents discarded", data_ok, 0);
    wr_en = 1'b1; wr_data = 36'hD_0000_0001; tick();
    wr_en = 1'b0; tick();
    chk("R9 mode kept: falls through", data_ok, 1);
    chk("R9 mode kept: word shown", rd_data, 36'hD_0000_0001);
    rd_en = 1'b1; tick();
    rd_en = 1'b0;
    chk("R9 old words gone", data_ok, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule